// File: doc/BRIEF.md
# Loop Counter and Branch Decision Unit

This block decides control flow for a small 16-bit sequencer that runs 32-bit instructions. It also holds the sequencer's 8-bit loop counter. For each valid operation it reports the program counter of the next instruction, whether a branch was taken, and how many clock cycles the step costs. The report appears one clock after the operation is presented.

Three kinds of operation are handled:

- **Counter operations.** These clear the loop counter, or add or subtract an 8-bit amount. The counter wraps modulo 256.
- **Absolute jumps.** The target is either a word address held in a register or a 4-byte-aligned byte immediate. The jump is unconditional, or it depends on the stored zero flag or overflow flag of the last ALU operation.
- **Relative jumps.** These compare either R0 or the loop counter against an immediate threshold. When the comparison holds, they add a signed byte step, converted to words, to the PC.

The ALU zero and overflow flags are captured only when the ALU signals an update. They therefore survive any number of branches and counter operations. Instruction fetch, the ALU datapath and memory access sit outside this block.

Top module: `seq_branch_unit`

## Requirements
- R1: After reset, `stage_cnt` is 0, `res_valid` is 0 and `taken` is 0.
- R2: Counter operations are `op_code` 1 (clear to 0), 2 (add `cnt_amount`) and 3 (subtract `cnt_amount`). Results wrap modulo 2^CNT_W, and the new value is visible on `stage_cnt` one clock after the operation.
- R3: `op_code` 4 is an absolute jump to the word address in `reg_target`; only its low PC_W bits are used.
- R4: `op_code` 5 is an absolute jump to the byte address `imm_target`; the word PC taken is `imm_target` divided by 4.
- R5: For absolute jumps, `cond` selects the condition: 0 means always, 1 means the stored zero flag is set, 2 means the stored overflow flag is set, and 3 means never.
- R6: The stored zero and overflow flags load `alu_zero` and `alu_ovf` only on a clock where `flag_we` is 1. They hold their value through counter operations and branches.
- R7: `op_code` 6 compares `r0_val` against `threshold` as unsigned numbers. `cond` 0 is equal, 1 is less-than, 2 is greater-than, and 3 is never taken.
- R8: `op_code` 7 compares the loop counter value from before the operation against `threshold` as unsigned numbers. `cond` 0 is less-than, 1 is less-or-equal, 2 is greater-or-equal, and 3 is never taken.
- R9: A taken relative jump goes to `pc` plus `step_bytes` divided by 4. The step is signed (two's complement), the division rounds toward minus infinity, and the sum wraps modulo 2^PC_W.
- R10: When no branch is taken, `next_pc` is `pc + 1` modulo 2^PC_W.
- R11: `cycles` reports EXEC_CYC + FETCH_SHORT (4 by default) for a branch operation and EXEC_CYC + FETCH_LONG (6 by default) for a counter operation. A counter operation never reports taken.
- R12: `res_valid` pulses high for one clock exactly one clock after each operation with `op_valid` 1 and a nonzero `op_code`, and stays low otherwise. Branch operations leave `stage_cnt` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An operation is presented this clock |
| op_code | input | 3 | Operation: 0 none, 1..3 counter, 4..7 branch |
| cond | input | 2 | Condition selector for branches |
| pc | input | PC_W | Word PC of the current instruction |
| reg_target | input | DATA_W | Register word address for op 4 |
| imm_target | input | IMM_W | Byte address immediate for op 5 |
| step_bytes | input | STEP_W | Signed relative step in bytes |
| threshold | input | DATA_W | Unsigned compare threshold |
| r0_val | input | DATA_W | Current value of R0 |
| cnt_amount | input | CNT_W | Counter add/subtract amount |
| flag_we | input | 1 | ALU flag capture strobe |
| alu_zero | input | 1 | ALU result-was-zero flag |
| alu_ovf | input | 1 | ALU overflow flag |
| res_valid | output | 1 | Result outputs are valid |
| next_pc | output | PC_W | Next word PC |
| taken | output | 1 | Branch was taken |
| cycles | output | CYC_W | Cycles consumed by the step |
| stage_cnt | output | CNT_W | Loop counter value |

## Verification
A corrupted loop counter shows on `stage_cnt` one clock after the counter operation that caused it. It also shows in the taken bit of the next counter-relative jump, because that jump compares the old value. A stale or wrongly updated flag register shows nothing on its own; it appears only when a later zero- or overflow-conditioned absolute jump reports the wrong `taken` and `next_pc`. The bench therefore places counter operations and other branches between a flag capture and the jump that reads the flag. A wrong target sum or step conversion shows on `next_pc` in the clock after the branch, including the cases where the PC wraps.

// File: rtl/seq_br_pkg.sv
package seq_br_pkg;
   typedef enum logic [2:0] {
      BR_NOP     = 3'd0,
      BR_CNT_CLR = 3'd1,
      BR_CNT_ADD = 3'd2,
      BR_CNT_SUB = 3'd3,
      BR_JMP_REG = 3'd4,
      BR_JMP_IMM = 3'd5,
      BR_REL_R0  = 3'd6,
      BR_REL_CNT = 3'd7
   } br_op_e;

   localparam logic [1:0] C_ABS_ALWAYS = 2'd0;
   localparam logic [1:0] C_ABS_ZERO   = 2'd1;
   localparam logic [1:0] C_ABS_OVF    = 2'd2;
   localparam logic [1:0] C_R0_EQ      = 2'd0;
   localparam logic [1:0] C_R0_LT      = 2'd1;
   localparam logic [1:0] C_R0_GT      = 2'd2;
   localparam logic [1:0] C_CNT_LT     = 2'd0;
   localparam logic [1:0] C_CNT_LE     = 2'd1;
   localparam logic [1:0] C_CNT_GE     = 2'd2;
endpackage

// File: rtl/seq_stage_cnt.sv
module seq_stage_cnt #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             do_clr,
   input  logic             do_add,
   input  logic             do_sub,
   input  logic [CNT_W-1:0] amount,
   output logic [CNT_W-1:0] count
);
   // Modulo 2^CNT_W arithmetic: carries and borrows fall off the top.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (do_clr) count <= '0;
      else if (do_add) count <= count + amount;
      else if (do_sub) count <= count - amount;
   end
endmodule

// File: rtl/seq_br_cond.sv
module seq_br_cond
   import seq_br_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 8
) (
   input  logic [2:0]        op_code,
   input  logic [1:0]        cond,
   input  logic [DATA_W-1:0] r0_val,
   input  logic [DATA_W-1:0] threshold,
   input  logic [CNT_W-1:0]  count,
   input  logic              flag_z,
   input  logic              flag_o,
   output logic              take
);
   logic [DATA_W-1:0] cnt_ext;
   logic              r0_eq, r0_lt, cn_eq, cn_lt;
   br_op_e            opc;

   assign opc     = br_op_e'(op_code);
   assign cnt_ext = {{(DATA_W-CNT_W){1'b0}}, count};
   assign r0_eq   = (r0_val == threshold);
   assign r0_lt   = (r0_val <  threshold);
   assign cn_eq   = (cnt_ext == threshold);
   assign cn_lt   = (cnt_ext <  threshold);

   always_comb begin
      take = 1'b0;
      unique case (opc)
         BR_JMP_REG, BR_JMP_IMM: begin
            case (cond)
               C_ABS_ALWAYS: take = 1'b1;
               C_ABS_ZERO:   take = flag_z;
               C_ABS_OVF:    take = flag_o;
               default:      take = 1'b0;
            endcase
         end
         BR_REL_R0: begin
            case (cond)
               C_R0_EQ: take = r0_eq;
               C_R0_LT: take = r0_lt;
               C_R0_GT: take = !r0_lt && !r0_eq;
               default: take = 1'b0;
            endcase
         end
         BR_REL_CNT: begin
            case (cond)
               C_CNT_LT: take = cn_lt;
               C_CNT_LE: take = cn_lt || cn_eq;
               C_CNT_GE: take = !cn_lt;
               default:  take = 1'b0;
            endcase
         end
         default: take = 1'b0;
      endcase
   end
endmodule

// File: rtl/seq_br_target.sv
module seq_br_target
   import seq_br_pkg::*;
#(
   parameter int PC_W   = 11,
   parameter int DATA_W = 16,
   parameter int IMM_W  = 13,
   parameter int STEP_W = 10
) (
   input  logic [2:0]        op_code,
   input  logic [PC_W-1:0]   pc,
   input  logic [DATA_W-1:0] reg_target,
   input  logic [IMM_W-1:0]  imm_target,
   input  logic [STEP_W-1:0] step_bytes,
   output logic [PC_W-1:0]   target
);
   localparam int IMM_WORD_W  = IMM_W - 2;
   localparam int STEP_WORD_W = STEP_W - 2;

   logic [PC_W-1:0] reg_word, imm_word, step_word;
   br_op_e          opc;

   assign opc = br_op_e'(op_code);

   // Register target already counts words: truncate or zero-extend.
   if (DATA_W >= PC_W) begin : g_reg_trunc
      assign reg_word = reg_target[PC_W-1:0];
   end else begin : g_reg_ext
      assign reg_word = {{(PC_W-DATA_W){1'b0}}, reg_target};
   end

   // Immediate target counts bytes: drop the two alignment bits.
   if (IMM_WORD_W >= PC_W) begin : g_imm_trunc
      assign imm_word = imm_target[PC_W+1:2];
   end else begin : g_imm_ext
      assign imm_word = {{(PC_W-IMM_WORD_W){1'b0}}, imm_target[IMM_W-1:2]};
   end

   // Signed byte step to signed word step (floor division by 4).
   if (STEP_WORD_W >= PC_W) begin : g_step_trunc
      assign step_word = step_bytes[PC_W+1:2];
   end else begin : g_step_ext
      assign step_word = {{(PC_W-STEP_WORD_W){step_bytes[STEP_W-1]}},
                          step_bytes[STEP_W-1:2]};
   end

   always_comb begin
      unique case (opc)
         BR_JMP_REG: target = reg_word;
         BR_JMP_IMM: target = imm_word;
         default:    target = pc + step_word;
      endcase
   end
endmodule

// File: rtl/seq_branch_unit.sv
module seq_branch_unit
   import seq_br_pkg::*;
#(
   parameter int PC_W        = 11,
   parameter int DATA_W      = 16,
   parameter int CNT_W       = 8,
   parameter int IMM_W       = 13,
   parameter int STEP_W      = 10,
   parameter int EXEC_CYC    = 2,
   parameter int FETCH_SHORT = 2,
   parameter int FETCH_LONG  = 4,
   parameter int CYC_W       = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [2:0]        op_code,
   input  logic [1:0]        cond,
   input  logic [PC_W-1:0]   pc,
   input  logic [DATA_W-1:0] reg_target,
   input  logic [IMM_W-1:0]  imm_target,
   input  logic [STEP_W-1:0] step_bytes,
   input  logic [DATA_W-1:0] threshold,
   input  logic [DATA_W-1:0] r0_val,
   input  logic [CNT_W-1:0]  cnt_amount,
   input  logic              flag_we,
   input  logic              alu_zero,
   input  logic              alu_ovf,
   output logic              res_valid,
   output logic [PC_W-1:0]   next_pc,
   output logic              taken,
   output logic [CYC_W-1:0]  cycles,
   output logic [CNT_W-1:0]  stage_cnt
);
   localparam logic [CYC_W-1:0] CYC_BR  = CYC_W'(EXEC_CYC + FETCH_SHORT);
   localparam logic [CYC_W-1:0] CYC_CNT = CYC_W'(EXEC_CYC + FETCH_LONG);
   localparam logic [PC_W-1:0]  PC_ONE  = PC_W'(1);

   if (DATA_W < CNT_W) begin : g_chk_cnt
      $error("DATA_W must be at least CNT_W");
   end
   if (IMM_W < 3 || STEP_W < 3 || PC_W < 2) begin : g_chk_imm
      $error("IMM_W and STEP_W must be at least 3, PC_W at least 2");
   end
   if ((EXEC_CYC + FETCH_LONG) >= (1 << CYC_W) || (EXEC_CYC + FETCH_SHORT) >= (1 << CYC_W)) begin : g_chk_cyc
      $error("CYC_W too narrow for the cycle counts");
   end

   br_op_e          opc;
   logic            is_cnt, is_br, take, flag_z, flag_o;
   logic [PC_W-1:0] tgt;

   assign opc    = br_op_e'(op_code);
   assign is_cnt = op_valid && (opc == BR_CNT_CLR || opc == BR_CNT_ADD || opc == BR_CNT_SUB);
   assign is_br  = op_valid && op_code[2];

   seq_stage_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .do_clr (op_valid && opc == BR_CNT_CLR),
      .do_add (op_valid && opc == BR_CNT_ADD),
      .do_sub (op_valid && opc == BR_CNT_SUB),
      .amount (cnt_amount),
      .count  (stage_cnt)
   );

   seq_br_cond #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cond (
      .op_code   (op_code),
      .cond      (cond),
      .r0_val    (r0_val),
      .threshold (threshold),
      .count     (stage_cnt),
      .flag_z    (flag_z),
      .flag_o    (flag_o),
      .take      (take)
   );

   seq_br_target #(.PC_W(PC_W), .DATA_W(DATA_W), .IMM_W(IMM_W), .STEP_W(STEP_W)) u_tgt (
      .op_code    (op_code),
      .pc         (pc),
      .reg_target (reg_target),
      .imm_target (imm_target),
      .step_bytes (step_bytes),
      .target     (tgt)
   );

   // ALU flag store: loads only on the ALU strobe.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag_z <= 1'b0;
         flag_o <= 1'b0;
      end else if (flag_we) begin
         flag_z <= alu_zero;
         flag_o <= alu_ovf;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         taken     <= 1'b0;
         next_pc   <= '0;
         cycles    <= '0;
      end else begin
         res_valid <= is_cnt || is_br;
         if (is_cnt || is_br) begin
            taken   <= is_br && take;
            next_pc <= (is_br && take) ? tgt : pc + PC_ONE;
            cycles  <= is_br ? CYC_BR : CYC_CNT;
         end
      end
   end
endmodule

// File: rtl/seq_branch_unit_chk.sv
module seq_branch_unit_chk #(
   parameter int PC_W        = 11,
   parameter int CNT_W       = 8,
   parameter int EXEC_CYC    = 2,
   parameter int FETCH_SHORT = 2,
   parameter int FETCH_LONG  = 4,
   parameter int CYC_W       = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             op_valid,
   input logic [2:0]       op_code,
   input logic [1:0]       cond,
   input logic [PC_W-1:0]  pc,
   input logic             res_valid,
   input logic [PC_W-1:0]  next_pc,
   input logic             taken,
   input logic [CYC_W-1:0] cycles,
   input logic [CNT_W-1:0] stage_cnt
);
   localparam logic [CYC_W-1:0] CS = CYC_W'(EXEC_CYC + FETCH_SHORT);
   localparam logic [CYC_W-1:0] CL = CYC_W'(EXEC_CYC + FETCH_LONG);
   localparam logic [PC_W-1:0]  P1 = PC_W'(1);

   AST_RESULT_FOLLOWS_OP: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code != 3'd0) |=> res_valid); // R12
   AST_NO_IDLE_RESULT: assert property (@(posedge clk) disable iff (!rst_n) !(op_valid && op_code != 3'd0) |=> !res_valid); // R12
   AST_BRANCH_KEEPS_CNT: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code[2]) |=> $stable(stage_cnt)); // R12
   AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code == 3'd1) |=> stage_cnt == '0); // R2
   AST_CNT_OP_COST: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code != 3'd0 && !op_code[2]) |=> (!taken && cycles == CL)); // R11
   AST_BRANCH_COST: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code[2]) |=> cycles == CS); // R11
   AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code[2]) |=> (taken || next_pc == $past(pc) + P1)); // R10
   AST_NEVER_COND: assert property (@(posedge clk) disable iff (!rst_n) (op_valid && op_code[2] && cond == 2'd3) |=> !taken); // R5
endmodule

bind seq_branch_unit seq_branch_unit_chk #(
   .PC_W(PC_W), .CNT_W(CNT_W), .EXEC_CYC(EXEC_CYC),
   .FETCH_SHORT(FETCH_SHORT), .FETCH_LONG(FETCH_LONG), .CYC_W(CYC_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .cond(cond),
   .pc(pc), .res_valid(res_valid), .next_pc(next_pc), .taken(taken),
   .cycles(cycles), .stage_cnt(stage_cnt)
);

// File: tb/tb_seq_branch_unit.sv
module tb_seq_branch_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [2:0]  op_code = '0;
   logic [1:0]  cond = '0;
   logic [10:0] pc = '0;
   logic [15:0] reg_target = '0;
   logic [12:0] imm_target = '0;
   logic [9:0]  step_bytes = '0;
   logic [15:0] threshold = '0;
   logic [15:0] r0_val = '0;
   logic [7:0]  cnt_amount = '0;
   logic        flag_we = 1'b0;
   logic        alu_zero = 1'b0;
   logic        alu_ovf = 1'b0;
   logic        res_valid, taken;
   logic [10:0] next_pc;
   logic [2:0]  cycles;
   logic [7:0]  stage_cnt;

   int total = 0;
   int bad = 0;
   bit finished = 0;

   typedef struct {
      logic [10:0] npc;
      logic        tk;
      logic [2:0]  cyc;
      logic [7:0]  cnt;
      string       req;
   } exp_t;
   exp_t sb[$];

   // Bench model state
   logic [7:0] m_cnt = '0;
   logic       m_z = 1'b0;
   logic       m_o = 1'b0;

   always #2.5 clk = ~clk;

   seq_branch_unit dut (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code), .cond(cond),
      .pc(pc), .reg_target(reg_target), .imm_target(imm_target), .step_bytes(step_bytes),
      .threshold(threshold), .r0_val(r0_val), .cnt_amount(cnt_amount), .flag_we(flag_we),
      .alu_zero(alu_zero), .alu_ovf(alu_ovf), .res_valid(res_valid), .next_pc(next_pc),
      .taken(taken), .cycles(cycles), .stage_cnt(stage_cnt)
   );

   task automatic drive_op(input logic [2:0] op, input logic [1:0] c, input logic [10:0] p,
                           input logic [15:0] rt, input logic [12:0] it, input logic [9:0] st,
                           input logic [15:0] th, input logic [15:0] r0, input logic [7:0] amt,
                           input string req);
      exp_t e;
      logic ok;
      logic [10:0] tgt;
      int si;
      ok = 1'b0;
      tgt = '0;
      si = $signed(st);
      case (op)
         3'd1: m_cnt = 8'd0;
         3'd2: m_cnt = m_cnt + amt;
         3'd3: m_cnt = m_cnt - amt;
         3'd4, 3'd5: begin
            ok  = (c == 2'd0) || (c == 2'd1 && m_z) || (c == 2'd2 && m_o);
            tgt = (op == 3'd4) ? rt[10:0] : 11'(it / 13'd4);
         end
         3'd6: begin
            ok  = (c == 2'd0 && r0 == th) || (c == 2'd1 && r0 < th) || (c == 2'd2 && r0 > th);
            tgt = 11'(int'(p) + (si >>> 2));
         end
         default: begin
            ok  = (c == 2'd0 && {8'd0, m_cnt} < th) || (c == 2'd1 && {8'd0, m_cnt} <= th) ||
                  (c == 2'd2 && {8'd0, m_cnt} >= th);
            tgt = 11'(int'(p) + (si >>> 2));
         end
      endcase
      e.tk  = ok;
      e.npc = ok ? tgt : p + 11'd1;
      e.cyc = op[2] ? 3'd4 : 3'd6;
      e.cnt = m_cnt;
      e.req = req;
      @(negedge clk);
      op_valid = 1'b1; op_code = op; cond = c; pc = p; reg_target = rt; imm_target = it;
      step_bytes = st; threshold = th; r0_val = r0; cnt_amount = amt; flag_we = 1'b0;
      sb.push_back(e);
   endtask

   task automatic set_flags(input logic z, input logic o);
      @(negedge clk);
      op_valid = 1'b0; op_code = 3'd0; flag_we = 1'b1; alu_zero = z; alu_ovf = o;
      m_z = z; m_o = o;
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         op_valid = 1'b0; op_code = 3'd0; flag_we = 1'b0;
         // Stray flag inputs without the strobe must not be captured (R6)
         alu_zero = ~alu_zero; alu_ovf = ~alu_ovf;
      end
   endtask

   // Scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         total++;
         if (sb.size() == 0) begin
            bad++;
            $display("FAIL R12: unexpected result npc=%h exp=none", next_pc);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (next_pc !== e.npc || taken !== e.tk || cycles !== e.cyc || stage_cnt !== e.cnt) begin
               bad++;
               $display("FAIL %s: npc=%h tk=%b cyc=%0d cnt=%0d exp npc=%h tk=%b cyc=%0d cnt=%0d",
                        e.req, next_pc, taken, cycles, stage_cnt, e.npc, e.tk, e.cyc, e.cnt);
            end
         end
      end
   end

   initial begin
      repeat (2000) @(posedge clk);
      if (!finished) begin
         bad++; total++;
         $display("FAIL watchdog: run hung actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      total++;
      if (stage_cnt !== 8'd0 || res_valid !== 1'b0 || taken !== 1'b0) begin
         bad++;
         $display("FAIL R1: cnt=%0d valid=%b taken=%b exp 0 0 0", stage_cnt, res_valid, taken);
      end
      rst_n = 1'b1;
      idle(2);
      // R2 counter ops and wrap
      drive_op(3'd2, 2'd0, 11'd10, 0, 0, 0, 0, 0, 8'd10,  "R2");
      drive_op(3'd2, 2'd0, 11'd11, 0, 0, 0, 0, 0, 8'd250, "R2");
      drive_op(3'd3, 2'd0, 11'd12, 0, 0, 0, 0, 0, 8'd5,   "R2");
      drive_op(3'd1, 2'd0, 11'd13, 0, 0, 0, 0, 0, 8'd77,  "R2");
      drive_op(3'd2, 2'd0, 11'h7FF, 0, 0, 0, 0, 0, 8'd16, "R11");
      // R8 counter-relative compares (cnt=16), R9 steps, R10 fall-through
      drive_op(3'd7, 2'd0, 11'd100, 0, 0, 10'h3F8, 16'd16, 0, 0, "R8");
      drive_op(3'd7, 2'd1, 11'd100, 0, 0, 10'h3F8, 16'd16, 0, 0, "R9");
      drive_op(3'd7, 2'd2, 11'd100, 0, 0, 10'd16, 16'd20, 0, 0, "R10");
      drive_op(3'd7, 2'd2, 11'd100, 0, 0, 10'd16, 16'd3,  0, 0, "R8");
      drive_op(3'd7, 2'd3, 11'd100, 0, 0, 10'd16, 16'd3,  0, 0, "R8");
      // R6 flags captured, then held across other ops
      set_flags(1'b1, 1'b0);
      idle(1);
      drive_op(3'd4, 2'd1, 11'd5, 16'h0025, 0, 0, 0, 0, 0, "R3");
      drive_op(3'd4, 2'd2, 11'd5, 16'h0025, 0, 0, 0, 0, 0, "R5");
      drive_op(3'd2, 2'd0, 11'd6, 0, 0, 0, 0, 0, 8'd1, "R12");
      drive_op(3'd6, 2'd0, 11'd7, 0, 0, 10'd8, 16'd1, 16'd9, 0, "R12");
      idle(3);
      drive_op(3'd5, 2'd1, 11'd8, 0, 13'h0120, 0, 0, 0, 0, "R6");
      drive_op(3'd5, 2'd0, 11'd8, 0, 13'h1FFC, 0, 0, 0, 0, "R4");
      drive_op(3'd5, 2'd3, 11'd8, 0, 13'h0040, 0, 0, 0, 0, "R5");
      set_flags(1'b0, 1'b1);
      drive_op(3'd5, 2'd2, 11'd9, 0, 13'h0044, 0, 0, 0, 0, "R5");
      drive_op(3'd5, 2'd1, 11'd9, 0, 13'h0044, 0, 0, 0, 0, "R6");
      drive_op(3'd4, 2'd0, 11'd9, 16'hF812, 0, 0, 0, 0, 0, "R3");
      // R7 R0-relative compares, unsigned, with R9 wrap
      drive_op(3'd6, 2'd0, 11'h7FF, 0, 0, 10'd4, 16'd5, 16'd5, 0, "R9");
      drive_op(3'd6, 2'd1, 11'd20, 0, 0, 10'd12, 16'd5, 16'd3, 0, "R7");
      drive_op(3'd6, 2'd2, 11'd20, 0, 0, 10'd12, 16'd5, 16'd3, 0, "R7");
      drive_op(3'd6, 2'd2, 11'd20, 0, 0, 10'd12, 16'd5, 16'hFFFF, 0, "R7");
      drive_op(3'd6, 2'd1, 11'd20, 0, 0, 10'd12, 16'd5, 16'hFFFF, 0, "R7");
      drive_op(3'd6, 2'd3, 11'd20, 0, 0, 10'd12, 16'd5, 16'd5, 0, "R7");
      drive_op(3'd6, 2'd0, 11'd0, 0, 0, 10'h3FC, 16'd0, 16'd0, 0, "R9");
      idle(4);
      // R12: all expected results must have appeared, none left over
      total++;
      if (sb.size() != 0) begin
         bad++;
         $display("FAIL R12: pending=%0d expected=0", sb.size());
      end
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule